// File: doc/BRIEF.md
# Single-Level Page Descriptor Translator

This block turns a 32-bit I/O virtual address into a physical address by looking up one word-sized page descriptor in a flat table held in memory. The table has one entry for every 4 KiB page of a 4 GiB space, so it spans 2^20 entries, or 4 MiB. A client hands over a virtual address with a valid/ready handshake. The block computes where the matching descriptor lives, reads it through a simple memory read port, and returns the translated address on a second valid/ready handshake. Only one table fetch is in flight at any time.

When the descriptor is not marked valid, the access is not dropped. The block steers it into a 128-byte protect window whose base comes from a configuration register. The response carries a fault flag, and a one-cycle fault pulse carrying the offending virtual address goes to the fault-recording logic. Two registers on a small write port set up the block: the table base at offset 0x000 and the protect base at offset 0x214.

Top module: `ptx_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid`, `mem_req` and `flt_pulse` are low. Once reset is released, `req_ready` is high.
- R2: The descriptor fetch address is the table base plus the virtual page number (VA bits 31:12) times 4, computed modulo 2^32. A write to offset 0x000 sets the table base. Bits 1:0 of that write are forced to zero.
- R3: A descriptor with bit 1 set is valid. For a valid descriptor the response address is descriptor bits 31:12 joined with VA bits 11:0, `rsp_fault` is 0, and `rsp_nonsec` equals descriptor bit 3.
- R4: A descriptor with bit 1 clear gives `rsp_fault` = 1, `rsp_nonsec` = 0, and a response address of protect-base bits 31:7 joined with VA bits 6:0. A write to offset 0x214 sets the protect base. Bits 6:0 of that write are forced to zero.
- R5: A faulting translation raises `flt_pulse` for exactly one cycle, with `flt_va` equal to the full virtual address, in the first cycle `rsp_valid` is high. A valid translation raises no pulse.
- R6: `req_ready` is low from the cycle after a request is accepted until the cycle after its response is taken, so at most one fetch is outstanding.
- R7: Once `rsp_valid` rises, it stays high and the response fields stay unchanged until a cycle in which `rsp_ready` is high.
- R8: A table-base write in the same cycle a request is accepted does not affect that request's fetch address. A protect-base write in the same cycle a descriptor returns does not affect that response.
- R9: A `mem_rvalid` pulse while no fetch is pending is ignored and produces no response.
- R10: Writes to any offset other than 0x000 and 0x214 change neither register.
- R11: `mem_req` is high for exactly one cycle, the cycle after acceptance. `rsp_valid` rises in the cycle after the cycle in which `mem_rvalid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address to translate |
| mem_req | output | 1 | Descriptor read strobe |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Descriptor word returned |
| mem_rdata | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Client takes the response |
| rsp_pa | output | 32 | Translated or redirected address |
| rsp_fault | output | 1 | Descriptor was invalid, access redirected |
| rsp_nonsec | output | 1 | Mapping is marked non-secure |
| flt_pulse | output | 1 | One-cycle translation fault strobe |
| flt_va | output | 32 | Faulting virtual address |

## Verification
Two pairs of events can fall in the same cycle: a table-base write with request acceptance, and a protect-base write with descriptor return. The bench provokes the first by driving the write and the request in one cycle while the block is idle. It provokes the second from its memory responder, which fires the protect write in the exact cycle it returns the descriptor. The reference model judges both cases by resolving the translation with the old register value first and only then applying the write. Follow-up requests confirm that the new value took effect.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/ptx_cfg_regs.sv
module ptx_cfg_regs #(
  parameter int AW        = 32,
  parameter int CW        = 12,
  parameter int ENTRY_LOG2 = 2,
  parameter int PROT_LOG2 = 7,
  parameter logic [CW-1:0] BASE_OFF = 12'h000,
  parameter logic [CW-1:0] PROT_OFF = 12'h214
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_addr,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] tbl_base,
  output logic [AW-1:0] prot_base
);
  localparam logic [AW-1:0] BASE_KEEP = ~((AW'(1) << ENTRY_LOG2) - AW'(1));
  localparam logic [AW-1:0] PROT_KEEP = ~((AW'(1) << PROT_LOG2) - AW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_base  <= '0;
      prot_base <= '0;
    end else if (wr_en) begin
      if (wr_addr == BASE_OFF) tbl_base  <= wr_data & BASE_KEEP;
      if (wr_addr == PROT_OFF) prot_base <= wr_data & PROT_KEEP;
    end
  end
endmodule

// File: rtl/ptx_desc_decode.sv
module ptx_desc_decode #(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int VALID_BIT  = 1,
  parameter int NONSEC_BIT = 3,
  parameter int PROT_LOG2  = 7
) (
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] prot,
  output logic          hit,
  output logic [AW-1:0] pa,
  output logic          nonsec
);
  localparam logic [AW-1:0] PG_OFS = (AW'(1) << PAGE_SHIFT) - AW'(1);
  localparam logic [AW-1:0] PR_OFS = (AW'(1) << PROT_LOG2) - AW'(1);

  always_comb begin
    hit    = desc[VALID_BIT];
    nonsec = hit & desc[NONSEC_BIT];
    if (hit) pa = (desc & ~PG_OFS) | (va & PG_OFS);
    else     pa = (prot & ~PR_OFS) | (va & PR_OFS);
  end
endmodule

// File: rtl/ptx_walk_ctrl.sv
module ptx_walk_ctrl
  import ptx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_va,
  output logic          req_ready,
  input  logic [AW-1:0] tbl_base,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  output logic [AW-1:0] va_q,
  input  logic          dec_hit,
  input  logic [AW-1:0] dec_pa,
  input  logic          dec_nonsec,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_pa,
  output logic          rsp_fault,
  output logic          rsp_nonsec,
  output logic          flt_pulse,
  output logic [AW-1:0] flt_va
);
  walk_st_e      st;
  logic [AW-1:0] entry_off;

  assign entry_off = (req_va >> PAGE_SHIFT) << ENTRY_LOG2;
  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      va_q       <= '0;
      mem_addr   <= '0;
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_fault  <= 1'b0;
      rsp_nonsec <= 1'b0;
      flt_pulse  <= 1'b0;
      flt_va     <= '0;
    end else begin
      flt_pulse <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q     <= req_va;
          mem_addr <= tbl_base + entry_off;
          st       <= ST_FETCH;
        end
        ST_FETCH: st <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          rsp_valid  <= 1'b1;
          rsp_pa     <= dec_pa;
          rsp_fault  <= ~dec_hit;
          rsp_nonsec <= dec_nonsec;
          st         <= ST_RESP;
          if (!dec_hit) begin
            flt_pulse <= 1'b1;
            flt_va    <= va_q;
          end
        end
        ST_RESP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptx_xlate.sv
module ptx_xlate #(
  parameter int AW         = 32,
  parameter int CW         = 12,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2,
  parameter int VALID_BIT  = 1,
  parameter int NONSEC_BIT = 3,
  parameter int PROT_LOG2  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_va,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_pa,
  output logic          rsp_fault,
  output logic          rsp_nonsec,
  output logic          flt_pulse,
  output logic [AW-1:0] flt_va
);
  logic [AW-1:0] tbl_base, prot_base, va_q, dec_pa;
  logic          dec_hit, dec_nonsec;

  ptx_cfg_regs #(
    .AW(AW), .CW(CW), .ENTRY_LOG2(ENTRY_LOG2), .PROT_LOG2(PROT_LOG2),
    .BASE_OFF(CW'(12'h000)), .PROT_OFF(CW'(12'h214))
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .tbl_base(tbl_base), .prot_base(prot_base)
  );

  ptx_desc_decode #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .VALID_BIT(VALID_BIT),
    .NONSEC_BIT(NONSEC_BIT), .PROT_LOG2(PROT_LOG2)
  ) u_dec (
    .desc(mem_rdata), .va(va_q), .prot(prot_base),
    .hit(dec_hit), .pa(dec_pa), .nonsec(dec_nonsec)
  );

  ptx_walk_ctrl #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_LOG2(ENTRY_LOG2)
  ) u_walk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_ready(req_ready), .tbl_base(tbl_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .va_q(va_q),
    .dec_hit(dec_hit), .dec_pa(dec_pa), .dec_nonsec(dec_nonsec),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec),
    .flt_pulse(flt_pulse), .flt_va(flt_va)
  );
endmodule

// File: rtl/ptx_xlate_chk.sv
module ptx_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_pa,
  input logic          rsp_fault,
  input logic          rsp_nonsec,
  input logic          flt_pulse
);
  p_one_out_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) &&
                                   $stable(rsp_fault) && $stable(rsp_nonsec)));

  p_flt_single_r5: assert property (@(posedge clk) disable iff (rst)
    flt_pulse |=> !flt_pulse);

  p_flt_with_rsp_r5: assert property (@(posedge clk) disable iff (rst)
    flt_pulse |-> (rsp_valid && rsp_fault && $rose(rsp_valid)));

  p_fault_secure_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> !rsp_nonsec);

  p_fetch_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_req);

  p_fetch_once_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_rsp_after_data_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(mem_rvalid));
endmodule

bind ptx_xlate ptx_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .rsp_nonsec(rsp_nonsec), .flt_pulse(flt_pulse)
);

// File: tb/sim_ptx_xlate.sv
module sim_ptx_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic        rsp_fault, rsp_nonsec, flt_pulse;
  logic [31:0] flt_va;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptx_xlate u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_nonsec(rsp_nonsec), .flt_pulse(flt_pulse), .flt_va(flt_va)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // memory image of the descriptor table
  logic [31:0] mem_img [logic [31:0]];
  function automatic logic [31:0] rd_img(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h0;
  endfunction

  // memory responder controls
  int          dly = 0;
  logic        stray_go = 1'b0;
  logic        prot_on_ret = 1'b0;
  logic [31:0] prot_on_ret_val = '0;
  logic [7:0]  rdy_pat = 8'hFF;

  initial begin
    logic        pend = 1'b0;
    logic        own_cfg = 1'b0;
    int          cnt = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(posedge clk); #1;
      mem_rvalid = 1'b0;
      if (own_cfg) begin cfg_we = 1'b0; own_cfg = 1'b0; end
      if (pend) begin
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd_img(paddr);
          pend = 1'b0;
          if (prot_on_ret) begin
            cfg_we = 1'b1; cfg_addr = 12'h214; cfg_wdata = prot_on_ret_val;
            own_cfg = 1'b1; prot_on_ret = 1'b0;
          end
        end else cnt--;
      end else if (stray_go) begin
        mem_rvalid = 1'b1;
        mem_rdata  = 32'hFFFFF00A;
        stray_go   = 1'b0;
      end
      if (mem_req) begin pend = 1'b1; paddr = mem_addr; cnt = dly; end
    end
  end

  // response ready pattern
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      rsp_ready = rdy_pat[k % 8];
      k++;
    end
  end

  // behavioural reference model, compared every cycle
  logic        m_idle = 1'b1, m_fetch = 1'b0, m_wait = 1'b0, m_rsp = 1'b0, m_flt = 1'b0;
  logic [31:0] m_base = '0, m_prot = '0;
  logic [31:0] e_va = '0, e_addr = '0, e_pa = '0;
  logic        e_fault = 1'b0, e_ns = 1'b0;
  logic [31:0] last_pa = '0;
  logic        last_fault = 1'b0;

  always @(negedge clk) begin
    logic        idle_n, fetch_n, wait_n, rsp_n, flt_n;
    logic [31:0] d;
    if (rst) begin
      m_idle = 1'b1; m_fetch = 1'b0; m_wait = 1'b0; m_rsp = 1'b0; m_flt = 1'b0;
      m_base = '0; m_prot = '0;
    end else begin
      chk("R6 req_ready", {31'b0, req_ready}, {31'b0, m_idle});
      chk("R11 mem_req", {31'b0, mem_req}, {31'b0, m_fetch});
      chk("R7 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rsp});
      chk("R5 flt_pulse", {31'b0, flt_pulse}, {31'b0, m_flt});
      if (m_flt && flt_pulse) chk("R5 flt_va", flt_va, e_va);
      if (m_fetch && mem_req) chk("R2 mem_addr", mem_addr, e_addr);
      if (m_rsp && rsp_valid) begin
        chk(e_fault ? "R4 rsp_pa" : "R3 rsp_pa", rsp_pa, e_pa);
        chk("R3 R4 rsp_fault", {31'b0, rsp_fault}, {31'b0, e_fault});
        chk("R3 rsp_nonsec", {31'b0, rsp_nonsec}, {31'b0, e_ns});
        if (rsp_ready) begin last_pa = rsp_pa; last_fault = rsp_fault; end
      end
      idle_n = m_idle; fetch_n = 1'b0; wait_n = m_wait; rsp_n = m_rsp; flt_n = 1'b0;
      if (m_rsp && rsp_ready) begin rsp_n = 1'b0; idle_n = 1'b1; end
      if (m_idle && req_valid) begin
        idle_n = 1'b0; fetch_n = 1'b1; e_va = req_va;
        e_addr = m_base + {req_va[31:12], 2'b00};
      end
      if (m_fetch) wait_n = 1'b1;
      if (m_wait && mem_rvalid) begin
        d = mem_rdata;
        wait_n = 1'b0; rsp_n = 1'b1;
        if (d[1]) begin
          e_pa = {d[31:12], e_va[11:0]}; e_fault = 1'b0; e_ns = d[3];
        end else begin
          e_pa = {m_prot[31:7], e_va[6:0]}; e_fault = 1'b1; e_ns = 1'b0; flt_n = 1'b1;
        end
      end
      if (cfg_we) begin
        if (cfg_addr == 12'h000) m_base = cfg_wdata & 32'hFFFF_FFFC;
        if (cfg_addr == 12'h214) m_prot = cfg_wdata & 32'hFFFF_FF80;
      end
      m_idle = idle_n; m_fetch = fetch_n; m_wait = wait_n; m_rsp = rsp_n; m_flt = flt_n;
    end
  end

  task automatic cfg_wr(input logic [11:0] a, input logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (req_ready && !rsp_valid) break;
    end
  endtask

  task automatic send(input logic [31:0] va);
    @(posedge clk); #1;
    req_valid = 1'b1; req_va = va;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    wait_idle();
  endtask

  task automatic send_with_base(input logic [31:0] va, input logic [31:0] nb);
    wait_idle();
    @(posedge clk); #1;
    req_valid = 1'b1; req_va = va;
    cfg_we = 1'b1; cfg_addr = 12'h000; cfg_wdata = nb;
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    wait_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: run did not complete");
    finish_run();
  end

  localparam logic [31:0] B1 = 32'h0010_0000;
  localparam logic [31:0] B2 = 32'h0020_0000;

  initial begin
    mem_img[B1 + 32'h48] = 32'hABCDE00A;  // page 0x12: valid, non-secure
    mem_img[B1 + 32'h4C] = 32'h11111002;  // page 0x13: valid, secure
    mem_img[B1 + 32'h50] = 32'h55555008;  // page 0x14: invalid
    mem_img[B2 + 32'h48] = 32'h77777002;  // page 0x12 in second table

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
    chk("R1 flt_pulse", {31'b0, flt_pulse}, 32'h0);

    cfg_wr(12'h000, B1 | 32'h3);          // R2 low bits dropped
    cfg_wr(12'h214, 32'h2000_007F);       // R4 low bits dropped

    for (int pass = 0; pass < 4; pass++) begin
      dly = pass;
      rdy_pat = (pass == 0) ? 8'hFF : (pass == 1) ? 8'b1010_0110 :
                (pass == 2) ? 8'b1000_0000 : 8'b0011_0101;
      send(32'h0001_2345);
      chk("R3 valid nonsec pa", last_pa, 32'hABCD_E345);
      send(32'h0001_3FFF);
      chk("R3 valid secure pa", last_pa, 32'h1111_1FFF);
      send(32'h0001_4F7B);
      chk("R4 invalid redirect pa", last_pa, 32'h2000_007B);
      send(32'hFFFF_F123);
      chk("R4 unmapped redirect pa", last_pa, 32'h2000_0023);
    end

    rdy_pat = 8'hFF; dly = 1;
    // R10 writes to other offsets ignored
    cfg_wr(12'h004, 32'h0);
    cfg_wr(12'h210, 32'h0);
    cfg_wr(12'h218, 32'hFFFF_FFFF);
    send(32'h0001_2345);
    chk("R10 base kept", last_pa, 32'hABCD_E345);
    send(32'h0001_4F00);
    chk("R10 protect kept", last_pa, 32'h2000_0000);

    // R9 stray descriptor return while idle
    wait_idle();
    stray_go = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 no response from stray", {31'b0, rsp_valid}, 32'h0);
    send(32'h0001_3FFF);
    chk("R9 next translation intact", last_pa, 32'h1111_1FFF);

    // R8 base write in the acceptance cycle
    send_with_base(32'h0001_2345, B2);
    chk("R8 old base used", last_pa, 32'hABCD_E345);
    send(32'h0001_2345);
    chk("R8 new base applied", last_pa, 32'h7777_7345);

    // R8 protect write in the descriptor return cycle
    dly = 2;
    prot_on_ret_val = 32'h3000_0011;
    prot_on_ret = 1'b1;
    send(32'h0001_4F7B);
    chk("R8 old protect used", last_pa, 32'h2000_007B);
    send(32'h0001_4F7B);
    chk("R8 new protect applied", last_pa, 32'h3000_007B);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule